// File: doc/BRIEF.md
# Huffman Code Length and Canonical Code Generator

This block turns one complete set of symbol frequencies into a static Huffman code. A producer writes one frequency per symbol slot through a valid/ready port. A start pulse then launches an iterative engine. On every clock cycle the engine joins the two lightest live nodes into a single node that carries their summed weight. Each join makes every symbol under the two nodes one bit deeper. When fewer than two live nodes remain, the block shows a code length for every symbol, plus a canonical codeword derived from those lengths. A one-cycle done pulse marks the end of the run.

The frequency port applies back-pressure for the whole run. `in_ready` is high only while the block is idle. A producer that sees `in_ready` low must hold `in_valid`, `in_sym` and `in_freq` steady. A transfer happens only on a clock edge where `in_valid` and `in_ready` are both high. Control (`start`, `busy`, `done`) and the result vectors are plain level signals. The results stay valid from the done pulse until the next accepted start.

Top module: `huff_len_gen`

## Requirements
- R1: On a rising edge with `in_valid` and `in_ready` both high, `in_freq` is stored as the weight of slot `in_sym`. `in_ready` is low for the whole run, so a write offered while busy is not taken and does not change the stored table.
- R2: After reset the block is idle, with `in_ready` high, `busy` and `done` low, and all code lengths 0. A `start` sampled while idle makes `busy` high on the next cycle. A `start` while busy is ignored.
- R3: Each merge cycle selects the lightest live node and then the lightest of the rest. Ties go to the lower slot index. The sum is kept in the lower slot of the pair, and the higher slot dies. A symbol's code length is the number of merges its node took part in.
- R4: A symbol with frequency 0 never takes part in a merge and gets length 0 and codeword 0. If exactly one frequency is nonzero, that symbol gets length 1. If all are zero, every length is 0.
- R5: With slots 0..5 weighted 29, 5, 7, 12, 4, 8 and slots 6, 7 zero, the lengths are 1, 4, 3, 3, 4, 3, 0, 0.
- R6: When two or more frequencies are nonzero, the sum of frequency times length equals the sum of all merged weights. For the R5 set this is 146 bits, against 195 for a flat 3-bit code over 65 symbols.
- R7: Codewords are canonical. The order is by increasing length, then by increasing slot within one length. The first code is all zeros, and each later code is the previous one plus one, shifted left by the growth in length. Symbol s has its length at `code_len[s*LW +: LW]` and its codeword right-aligned at `code_word[s*CW +: CW]`, with LW = log2(NSYM) and CW = NSYM-1.
- R8: `done` is high for exactly one cycle. It comes max(1, number of nonzero frequencies) cycles after the edge that sampled `start`, and `busy` falls in that same cycle.
- R9: While idle and with no start, the code lengths and codewords hold their values.
- R10: When two or more frequencies are nonzero, the lengths satisfy the Kraft sum with equality: the sum of 2^-len over the nonzero symbols is exactly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A frequency write is offered |
| in_ready | output | 1 | The block accepts a write (high only while idle) |
| in_sym | input | log2(NSYM) | Slot index of the offered frequency |
| in_freq | input | WBITS | Frequency value |
| start | input | 1 | Begin a build from the stored frequencies |
| busy | output | 1 | The merge loop is running |
| done | output | 1 | One-cycle pulse when the results are final |
| code_len | output | NSYM*LW | Code length per symbol |
| code_word | output | NSYM*CW | Canonical codeword per symbol, right-aligned |

## Verification
The engine is run on a worked frequency set with known lengths, on tables that are all zero or have a single live slot, and on tables of equal weights, where only the tie rule decides the tree shape. It is also run on doubling weights, which force the deepest chain, and on a long pseudo-random sweep that mixes zero slots with several value ranges. Exact lengths and codewords expose selection and tie errors. The weighted-cost and Kraft checks expose a broken tree whatever the tie order, and the latency count exposes an extra or a missing merge. A write and a second start offered mid-run, followed by a rerun, show whether back-pressure and the busy lockout hold.

// File: rtl/huff_pkg.sv
package huff_pkg;
  typedef enum logic {
    HG_IDLE = 1'b0,
    HG_RUN  = 1'b1
  } hg_state_e;
endpackage

// File: rtl/huff_freq_table.sv
module huff_freq_table #(
  parameter int NSYM  = 8,
  parameter int WBITS = 12,
  parameter int SYMW  = $clog2(NSYM)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SYMW-1:0]         wr_sym,
  input  logic [WBITS-1:0]        wr_data,
  output logic [NSYM*WBITS-1:0]   freq_flat
);
  for (genvar g = 0; g < NSYM; g++) begin : g_slot
    logic [WBITS-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else if (wr_en && wr_sym == SYMW'(g)) slot_q <= wr_data;
    end
    assign freq_flat[g*WBITS +: WBITS] = slot_q;
  end
endmodule

// File: rtl/huff_min2.sv
module huff_min2 #(
  parameter int NSYM = 8,
  parameter int SW   = 15,
  parameter int SYMW = $clog2(NSYM)
) (
  input  logic [NSYM-1:0]      live,
  input  logic [NSYM*SW-1:0]   w_flat,
  output logic [SYMW-1:0]      first_idx,
  output logic [SYMW-1:0]      second_idx,
  output logic [SYMW:0]        n_live
);
  always_comb begin
    logic [SW-1:0] best1;
    logic [SW-1:0] best2;
    logic          got1;
    logic          got2;
    logic [SW-1:0] wv;
    best1      = '0;
    best2      = '0;
    got1       = 1'b0;
    got2       = 1'b0;
    first_idx  = '0;
    second_idx = '0;
    n_live     = '0;
    for (int i = 0; i < NSYM; i++) begin
      wv = w_flat[i*SW +: SW];
      if (live[i]) begin
        n_live = n_live + 1'b1;
        if (!got1 || wv < best1) begin
          best1     = wv;
          first_idx = SYMW'(i);
          got1      = 1'b1;
        end
      end
    end
    for (int i = 0; i < NSYM; i++) begin
      wv = w_flat[i*SW +: SW];
      if (live[i] && SYMW'(i) != first_idx) begin
        if (!got2 || wv < best2) begin
          best2      = wv;
          second_idx = SYMW'(i);
          got2       = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/huff_canon.sv
module huff_canon #(
  parameter int NSYM = 8,
  parameter int LW   = $clog2(NSYM),
  parameter int CW   = NSYM - 1
) (
  input  logic [NSYM*LW-1:0] len_flat,
  output logic [NSYM*CW-1:0] code_flat
);
  logic [CW-1:0] per_len_cnt [NSYM];
  logic [CW-1:0] base_code   [NSYM];
  logic [CW-1:0] sym_code    [NSYM];

  always_comb begin
    logic [LW-1:0] ls;
    logic [CW-1:0] rank;
    for (int l = 0; l < NSYM; l++) per_len_cnt[l] = '0;
    for (int s = 0; s < NSYM; s++) begin
      ls = len_flat[s*LW +: LW];
      per_len_cnt[ls] = per_len_cnt[ls] + 1'b1;
    end
    base_code[0] = '0;
    base_code[1] = '0;
    for (int l = 2; l < NSYM; l++)
      base_code[l] = (base_code[l-1] + per_len_cnt[l-1]) << 1;
    for (int s = 0; s < NSYM; s++) begin
      ls   = len_flat[s*LW +: LW];
      rank = '0;
      for (int j = 0; j < s; j++)
        if (len_flat[j*LW +: LW] == ls) rank = rank + 1'b1;
      sym_code[s] = (ls == '0) ? '0 : base_code[ls] + rank;
    end
  end

  for (genvar g = 0; g < NSYM; g++) begin : g_out
    assign code_flat[g*CW +: CW] = sym_code[g];
  end
endmodule

// File: rtl/huff_len_gen.sv
module huff_len_gen #(
  parameter int NSYM  = 8,
  parameter int WBITS = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [$clog2(NSYM)-1:0]           in_sym,
  input  logic [WBITS-1:0]                  in_freq,
  input  logic                              start,
  output logic                              busy,
  output logic                              done,
  output logic [NSYM*$clog2(NSYM)-1:0]      code_len,
  output logic [NSYM*(NSYM-1)-1:0]          code_word
);
  import huff_pkg::*;

  localparam int SYMW = $clog2(NSYM);
  localparam int LW   = $clog2(NSYM);
  localparam int CW   = NSYM - 1;
  localparam int SW   = WBITS + $clog2(NSYM);

  hg_state_e      state_q;
  logic           done_q;
  logic [SW-1:0]  w_q   [NSYM];
  logic [NSYM-1:0] live_q;
  logic [SYMW-1:0] grp_q [NSYM];
  logic [LW-1:0]  len_q [NSYM];

  logic [NSYM*WBITS-1:0] freq_flat;
  logic [NSYM*SW-1:0]    w_flat;
  logic [NSYM*LW-1:0]    len_flat;
  logic [SYMW-1:0]       sel_a, sel_b, m_lo, m_hi;
  logic [SYMW:0]         n_live;
  logic [SW-1:0]         m_sum;
  logic                  accept;

  assign in_ready = (state_q == HG_IDLE);
  assign busy     = (state_q == HG_RUN);
  assign done     = done_q;
  assign accept   = in_valid && in_ready;

  huff_freq_table #(.NSYM(NSYM), .WBITS(WBITS), .SYMW(SYMW)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (accept),
    .wr_sym    (in_sym),
    .wr_data   (in_freq),
    .freq_flat (freq_flat)
  );

  for (genvar g = 0; g < NSYM; g++) begin : g_flat
    assign w_flat[g*SW +: SW]   = w_q[g];
    assign len_flat[g*LW +: LW] = len_q[g];
  end

  huff_min2 #(.NSYM(NSYM), .SW(SW), .SYMW(SYMW)) u_min2 (
    .live       (live_q),
    .w_flat     (w_flat),
    .first_idx  (sel_a),
    .second_idx (sel_b),
    .n_live     (n_live)
  );

  assign m_lo  = (sel_a < sel_b) ? sel_a : sel_b;
  assign m_hi  = (sel_a < sel_b) ? sel_b : sel_a;
  assign m_sum = w_q[sel_a] + w_q[sel_b];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HG_IDLE;
      done_q  <= 1'b0;
      live_q  <= '0;
      for (int s = 0; s < NSYM; s++) begin
        w_q[s]   <= '0;
        grp_q[s] <= SYMW'(s);
        len_q[s] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (state_q)
        HG_IDLE: begin
          if (start) begin
            for (int s = 0; s < NSYM; s++) begin
              w_q[s]    <= SW'(freq_flat[s*WBITS +: WBITS]);
              live_q[s] <= (freq_flat[s*WBITS +: WBITS] != '0);
              grp_q[s]  <= SYMW'(s);
              len_q[s]  <= '0;
            end
            state_q <= HG_RUN;
          end
        end
        HG_RUN: begin
          if (n_live >= (SYMW+1)'(2)) begin
            w_q[m_lo]    <= m_sum;
            live_q[m_hi] <= 1'b0;
            for (int s = 0; s < NSYM; s++) begin
              if (grp_q[s] == sel_a || grp_q[s] == sel_b) begin
                len_q[s] <= len_q[s] + 1'b1;
                grp_q[s] <= m_lo;
              end
            end
          end else begin
            if (n_live == (SYMW+1)'(1) && len_q[sel_a] == '0)
              len_q[sel_a] <= LW'(1);
            done_q  <= 1'b1;
            state_q <= HG_IDLE;
          end
        end
        default: state_q <= HG_IDLE;
      endcase
    end
  end

  assign code_len = len_flat;

  huff_canon #(.NSYM(NSYM), .LW(LW), .CW(CW)) u_canon (
    .len_flat  (len_flat),
    .code_flat (code_word)
  );
endmodule

// File: rtl/huff_len_gen_chk.sv
module huff_len_gen_chk #(
  parameter int NSYM = 8,
  parameter int LW   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               in_ready,
  input logic               busy,
  input logic               done,
  input logic [NSYM*LW-1:0] code_len
);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && in_ready) |=> !in_ready);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(code_len));
endmodule

bind huff_len_gen huff_len_gen_chk #(.NSYM(NSYM), .LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .in_ready (in_ready),
  .busy     (busy),
  .done     (done),
  .code_len (code_len)
);

// File: tb/test_huff_len_gen.sv
`timescale 1ns/1ps
module test_huff_len_gen;
  localparam int NSYM = 8;
  localparam int WB   = 12;
  localparam int LW   = 3;
  localparam int CW   = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic start = 1'b0;
  logic [2:0] in_sym = '0;
  logic [WB-1:0] in_freq = '0;
  wire in_ready, busy, done;
  wire [NSYM*LW-1:0] code_len;
  wire [NSYM*CW-1:0] code_word;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  huff_len_gen #(.NSYM(NSYM), .WBITS(WB)) i_huff_len_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym(in_sym), .in_freq(in_freq), .start(start), .busy(busy),
    .done(done), .code_len(code_len), .code_word(code_word)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int dlen(int s);
    return int'(code_len[s*LW +: LW]);
  endfunction

  function automatic int dcode(int s);
    return int'(code_word[s*CW +: CW]);
  endfunction

  // Reference merge from R3/R4: lightest first, ties to lower slot, sum kept in lower slot.
  task automatic model(input int fr[NSYM], output int ml[NSYM], output int cost);
    int w[NSYM]; bit a[NSYM]; int g[NSYM];
    int n, i1, i2, lo, hi, sm;
    cost = 0;
    for (int s = 0; s < NSYM; s++) begin
      w[s] = fr[s]; a[s] = (fr[s] != 0); g[s] = s; ml[s] = 0;
    end
    n = 0;
    for (int s = 0; s < NSYM; s++) if (a[s]) n++;
    if (n == 1) begin
      for (int s = 0; s < NSYM; s++) if (a[s]) ml[s] = 1;
    end
    while (n >= 2) begin
      i1 = -1; i2 = -1;
      for (int s = 0; s < NSYM; s++) if (a[s] && (i1 < 0 || w[s] < w[i1])) i1 = s;
      for (int s = 0; s < NSYM; s++) if (a[s] && s != i1 && (i2 < 0 || w[s] < w[i2])) i2 = s;
      lo = (i1 < i2) ? i1 : i2;
      hi = (i1 < i2) ? i2 : i1;
      sm = w[i1] + w[i2];
      cost += sm;
      for (int s = 0; s < NSYM; s++)
        if (fr[s] != 0 && (g[s] == i1 || g[s] == i2)) begin ml[s]++; g[s] = lo; end
      w[lo] = sm; a[hi] = 0; n--;
    end
  endtask

  task automatic load(input int fr[NSYM]);
    for (int s = 0; s < NSYM; s++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sym = 3'(s); in_freq = WB'(fr[s]);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Pulses start, waits for done, checks timing; disturb adds a mid-run write and start.
  task automatic run_build(input int nz, input bit disturb);
    int k; int exp_k;
    exp_k = (nz > 1) ? nz : 1;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    k = 0;
    while (k < 100) begin
      if (disturb && k == 1) begin
        in_valid = 1'b1; in_sym = 3'd0; in_freq = WB'(1); start = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      if (disturb && k == 1) begin
        chk(in_ready == 1'b0, "R1", "in_ready while busy", in_ready, 0);
        in_valid = 1'b0; start = 1'b0;
      end
      k++;
      if (done) break;
    end
    chk(k == exp_k, "R8", "done latency", k, exp_k);
    chk(busy == 1'b0, "R8", "busy low with done", busy, 0);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done single cycle", done, 0);
  endtask

  task automatic verify(input int fr[NSYM], input string tag);
    int ml[NSYM]; int cost; int nz; int ec[NSYM];
    int code, prev; bit first; int wsum; int kraft;
    model(fr, ml, cost);
    nz = 0;
    for (int s = 0; s < NSYM; s++) if (fr[s] != 0) nz++;
    for (int s = 0; s < NSYM; s++) begin
      if (fr[s] == 0) chk(dlen(s) == 0, "R4", {tag, " zero slot length"}, dlen(s), 0);
      else chk(dlen(s) == ml[s], "R3", {tag, " length"}, dlen(s), ml[s]);
    end
    // R7 canonical assignment by running counter.
    code = 0; prev = 0; first = 1;
    for (int s = 0; s < NSYM; s++) ec[s] = 0;
    for (int l = 1; l < NSYM; l++)
      for (int s = 0; s < NSYM; s++)
        if (ml[s] == l) begin
          if (first) begin code = 0; first = 0; end
          else code = code << (l - prev);
          ec[s] = code; code++; prev = l;
        end
    for (int s = 0; s < NSYM; s++)
      chk(dcode(s) == ec[s], "R7", {tag, " codeword"}, dcode(s), ec[s]);
    if (nz >= 2) begin
      wsum = 0; kraft = 0;
      for (int s = 0; s < NSYM; s++) begin
        wsum += fr[s] * dlen(s);
        if (fr[s] != 0 && dlen(s) > 0) kraft += 1 << (CW - dlen(s));
      end
      chk(wsum == cost, "R6", {tag, " weighted length"}, wsum, cost);
      chk(kraft == (1 << CW), "R10", {tag, " Kraft sum"}, kraft, 1 << CW);
    end
  endtask

  task automatic full(input int fr[NSYM], input string tag);
    int nz;
    nz = 0;
    for (int s = 0; s < NSYM; s++) if (fr[s] != 0) nz++;
    load(fr);
    run_build(nz, 1'b0);
    verify(fr, tag);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int fr[NSYM];
    int snap[NSYM];
    int wsum;
    int unsigned seed;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R2", "reset in_ready", in_ready, 1);
    chk(busy == 1'b0, "R2", "reset busy", busy, 0);
    chk(done == 1'b0, "R2", "reset done", done, 0);
    chk(code_len == '0, "R2", "reset lengths", code_len, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 worked set, with a write and a start offered mid-run (R1, R2).
    fr = '{29, 5, 7, 12, 4, 8, 0, 0};
    load(fr);
    run_build(6, 1'b1);
    chk(dlen(0) == 1, "R5", "slot0 length", dlen(0), 1);
    chk(dlen(1) == 4, "R5", "slot1 length", dlen(1), 4);
    chk(dlen(2) == 3, "R5", "slot2 length", dlen(2), 3);
    chk(dlen(3) == 3, "R5", "slot3 length", dlen(3), 3);
    chk(dlen(4) == 4, "R5", "slot4 length", dlen(4), 4);
    chk(dlen(5) == 3, "R5", "slot5 length", dlen(5), 3);
    wsum = 0;
    for (int s = 0; s < NSYM; s++) wsum += fr[s] * dlen(s);
    chk(wsum == 146, "R6", "worked set total bits", wsum, 146);
    chk(3 * 65 == 195 && wsum < 195, "R6", "beats flat code", wsum, 195);
    verify(fr, "worked");
    for (int s = 0; s < NSYM; s++) snap[s] = dlen(s);
    repeat (5) @(negedge clk);
    for (int s = 0; s < NSYM; s++)
      chk(dlen(s) == snap[s], "R9", "hold while idle", dlen(s), snap[s]);
    // Rerun without loading: the refused mid-run write must not have landed (R1).
    run_build(6, 1'b0);
    verify(fr, "rerun R1");

    // R4 all zero and single live slot.
    fr = '{0, 0, 0, 0, 0, 0, 0, 0};
    full(fr, "allzero");
    for (int s = 0; s < NSYM; s++) chk(dlen(s) == 0, "R4", "all zero length", dlen(s), 0);
    for (int p = 0; p < NSYM; p++) begin
      for (int s = 0; s < NSYM; s++) fr[s] = (s == p) ? 9 + p : 0;
      full(fr, "single");
      chk(dlen(p) == 1, "R4", "single live length", dlen(p), 1);
    end

    // Ties: equal weights; doubling weights force the deepest chain.
    fr = '{5, 5, 5, 5, 5, 5, 5, 5};
    full(fr, "equal");
    fr = '{1, 1, 2, 4, 8, 16, 32, 64};
    full(fr, "doubling");
    chk(dlen(0) == 7, "R3", "deepest chain", dlen(0), 7);

    // Sweep with zeros and varied ranges.
    seed = 32'h1234_5678;
    for (int v = 0; v < 300; v++) begin
      for (int s = 0; s < NSYM; s++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        fr[s] = int'((seed >> 16) % (v % 3 == 0 ? 4 : (v % 3 == 1 ? 40 : 4095)));
        if (((seed >> 9) & 7) == 0) fr[s] = 0;
        if (v % 3 == 0 && fr[s] == 0 && ((seed >> 5) & 1) == 1) fr[s] = 2;
      end
      full(fr, "sweep");
    end
    summary();
  end
endmodule